// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit runs the SM3 message schedule for a vector register group. Each 256-bit element group holds eight 32-bit words from the first source operand, treated as message words W0 to W7, and eight from the second source operand, treated as W8 to W15. For every group the unit produces the next eight schedule words, W16 to W23. Each source word is byte-reversed before use, and each result word is byte-reversed before it leaves. W19 to W23 depend on W16 to W20 from the same group, so the eight results form one combinational chain.

The core sends a command with the vector length, the start index, the element-width code and the register numbers and group size of the destination and second source. The unit checks legality first. An illegal command raises a one-cycle flag and produces nothing else. A legal command is executed as one register-file group read per cycle, from group vstart/8 up to group vl/8 (exclusive). Each read is answered one cycle later by a result beat that carries its group index. A done pulse marks completion, which is where the core clears its start index.

Top module: `sm3x_unit`

## Requirements
- R1: For each group, W16+j = P1(Wj ^ Wj+7 ^ rol(Wj+13,15)) ^ rol(Wj+3,7) ^ Wj+10 for j = 0..7, where P1(x) = x ^ rol(x,15) ^ rol(x,23). Words computed earlier in the same group feed the later words.
- R2: Source element k occupies bits [32k+31:32k] of each operand bus. It is byte-reversed to form word Wk (from `vs1_grp`) or word Wk+8 (from `vs2_grp`). Result word W16+k is byte-reversed and placed at bits [32k+31:32k] of `res_data`.
- R3: A legal command reads groups vstart/8, vstart/8+1, and so on up to vl/8-1, one per cycle. The first read is in the cycle after the command is accepted. When vl/8 <= vstart/8, nothing is read.
- R4: Each read cycle is followed in the next cycle by `res_valid`, with `res_idx` equal to the group index that was read.
- R5: A command whose `cmd_sew` is not 3'b010 (32-bit elements) is illegal.
- R6: A command whose `cmd_vstart` is not a multiple of 8 is illegal.
- R7: A command is illegal when the destination registers [vd, vd+2^lmul) overlap the second-source registers [vs2, vs2+2^lmul). Groups that only touch at their boundaries are legal.
- R8: An illegal command pulses `illegal` for one cycle, in the cycle after it is accepted. It causes no read, no result and no done.
- R9: `done` pulses together with the last result beat. For a legal command with no groups, it pulses in the cycle after acceptance.
- R10: `cmd_ready` is high only while no command is in progress, and it is low in every read cycle.
- R11: After reset, `cmd_ready` is high and `rd_en`, `res_valid`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted on valid |
| cmd_vl | input | VL_W | Vector length in elements |
| cmd_vstart | input | VL_W | Start element |
| cmd_sew | input | 3 | Element width code, 3'b010 = 32 bits |
| cmd_vd | input | 5 | Destination register number |
| cmd_vs2 | input | 5 | Second-source register number |
| cmd_lmul | input | 2 | log2 of registers per group |
| rd_en | output | 1 | Group read request this cycle |
| rd_idx | output | VL_W-3 | Group index to read |
| vs1_grp | input | 256 | First-source group (W0..W7), valid in the read cycle |
| vs2_grp | input | 256 | Second-source group (W8..W15), valid in the read cycle |
| res_valid | output | 1 | Result beat present |
| res_idx | output | VL_W-3 | Group index of the result |
| res_data | output | 256 | W16..W23, byte-reversed per word |
| done | output | 1 | Command completed |
| illegal | output | 1 | Command rejected |

## Verification
The hardest case to reach from the ports is the depth of the in-group dependency. Only an input whose low words disturb W16..W20 shows whether W21..W23 consume those fresh words or stale inputs. The bench drives dense pseudo-random words into every group and compares each beat against its own sequential model. Legality corners are exercised as well: groups that touch but do not overlap, a vector length that is not a multiple of eight, and a start index at the final group. These are placed deliberately in the command table.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned GRP_WRDS = 8;
    localparam int unsigned GRP_W    = WORD_W * GRP_WRDS;
    localparam logic [2:0]  SEW_32   = 3'b010;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t perm1(input word_t x);
        return x ^ rotl(x, 15) ^ rotl(x, 23);
    endfunction

    function automatic word_t byte_rev(input word_t x);
        word_t r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[8*b +: 8] = x[WORD_W - 8*(b+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/sm3x_legal.sv
module sm3x_legal
    import sm3x_pkg::*;
#(
    parameter int unsigned VL_W = 8
) (
    input  logic [VL_W-1:0] vstart,
    input  logic [2:0]      sew,
    input  logic [4:0]      vd,
    input  logic [4:0]      vs2,
    input  logic [1:0]      lmul,
    output logic            ok
);

    localparam int unsigned REG_EW = 6;

    logic [REG_EW-1:0] span;
    logic [REG_EW-1:0] vd_lo, vd_hi, s2_lo, s2_hi;
    logic              overlap;
    logic              aligned;
    logic              width_ok;

    always_comb begin
        span     = REG_EW'(1) << lmul;
        vd_lo    = {1'b0, vd};
        s2_lo    = {1'b0, vs2};
        vd_hi    = vd_lo + span;
        s2_hi    = s2_lo + span;
        overlap  = (vd_lo < s2_hi) && (s2_lo < vd_hi);
        aligned  = (vstart[2:0] == 3'b000);
        width_ok = (sew == SEW_32);
        ok       = width_ok && aligned && !overlap;
    end

endmodule

// File: rtl/sm3x_core.sv
module sm3x_core
    import sm3x_pkg::*;
(
    input  logic [GRP_W-1:0] old_grp,
    input  logic [GRP_W-1:0] new_grp,
    output logic [GRP_W-1:0] next_grp
);

    localparam int unsigned SCHED_N = 3 * GRP_WRDS;

    word_t sched [SCHED_N];

    always_comb begin
        for (int k = 0; k < GRP_WRDS; k++) begin
            sched[k]            = byte_rev(old_grp[WORD_W*k +: WORD_W]);
            sched[k + GRP_WRDS] = byte_rev(new_grp[WORD_W*k +: WORD_W]);
        end
        for (int j = 2 * GRP_WRDS; j < SCHED_N; j++) begin
            sched[j] = perm1(sched[j-16] ^ sched[j-9] ^ rotl(sched[j-3], 15))
                     ^ rotl(sched[j-13], 7) ^ sched[j-6];
        end
        for (int k = 0; k < GRP_WRDS; k++) begin
            next_grp[WORD_W*k +: WORD_W] = byte_rev(sched[k + 2*GRP_WRDS]);
        end
    end

endmodule

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
    import sm3x_pkg::*;
#(
    parameter int unsigned VL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_ok,
    input  logic [VL_W-4:0]   first_idx,
    input  logic [VL_W-4:0]   end_idx,
    output logic              cmd_ready,
    output logic              rd_en,
    output logic [VL_W-4:0]   rd_idx,
    input  logic [GRP_W-1:0]  grp_result,
    output logic              res_valid,
    output logic [VL_W-4:0]   res_idx,
    output logic [GRP_W-1:0]  res_data,
    output logic              done,
    output logic              illegal
);

    localparam int unsigned GI_W = VL_W - 3;

    typedef enum logic {PH_IDLE, PH_RUN} phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [GI_W-1:0]   idx;
        logic [GI_W-1:0]   stop;
        logic              rv;
        logic [GI_W-1:0]   ri;
        logic [GRP_W-1:0]  rdat;
        logic              dn;
        logic              il;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [GI_W:0] idx_inc;

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        st_d.dn = 1'b0;
        st_d.il = 1'b0;
        idx_inc = {1'b0, st_q.idx} + 1'b1;
        case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid) begin
                    if (!cmd_ok) begin
                        st_d.il = 1'b1;
                    end else if (first_idx >= end_idx) begin
                        st_d.dn = 1'b1;
                    end else begin
                        st_d.phase = PH_RUN;
                        st_d.idx   = first_idx;
                        st_d.stop  = end_idx;
                    end
                end
            end
            PH_RUN: begin
                st_d.rv   = 1'b1;
                st_d.ri   = st_q.idx;
                st_d.rdat = grp_result;
                if (idx_inc == {1'b0, st_q.stop}) begin
                    st_d.phase = PH_IDLE;
                    st_d.dn    = 1'b1;
                end else begin
                    st_d.idx = idx_inc[GI_W-1:0];
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = (st_q.phase == PH_IDLE);
    assign rd_en     = (st_q.phase == PH_RUN);
    assign rd_idx    = st_q.idx;
    assign res_valid = st_q.rv;
    assign res_idx   = st_q.ri;
    assign res_data  = st_q.rdat;
    assign done      = st_q.dn;
    assign illegal   = st_q.il;

    // R4: every read is answered by a beat for the same group
    a_r4_beat_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (res_valid && res_idx == $past(rd_idx)));

    // R3: a legal non-empty command starts reading at its first group
    a_r3_first_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_ok && first_idx < end_idx)
        |=> (rd_en && rd_idx == $past(first_idx)));

    // R3: reads advance by one group per cycle
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + 1'b1));

    // R9: a beat without done means more reads are still pending
    a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !done) |-> rd_en);

endmodule

// File: rtl/sm3x_unit.sv
module sm3x_unit
    import sm3x_pkg::*;
#(
    parameter int unsigned VL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [VL_W-1:0]   cmd_vl,
    input  logic [VL_W-1:0]   cmd_vstart,
    input  logic [2:0]        cmd_sew,
    input  logic [4:0]        cmd_vd,
    input  logic [4:0]        cmd_vs2,
    input  logic [1:0]        cmd_lmul,
    output logic              rd_en,
    output logic [VL_W-4:0]   rd_idx,
    input  logic [255:0]      vs1_grp,
    input  logic [255:0]      vs2_grp,
    output logic              res_valid,
    output logic [VL_W-4:0]   res_idx,
    output logic [255:0]      res_data,
    output logic              done,
    output logic              illegal
);

    localparam int unsigned GI_W = VL_W - 3;

    logic              legal_ok;
    logic [GRP_W-1:0]  expand_out;
    logic [GI_W-1:0]   first_idx;
    logic [GI_W-1:0]   end_idx;

    assign first_idx = cmd_vstart[VL_W-1:3];
    assign end_idx   = cmd_vl[VL_W-1:3];

    sm3x_legal #(.VL_W(VL_W)) u_legal (
        .vstart (cmd_vstart),
        .sew    (cmd_sew),
        .vd     (cmd_vd),
        .vs2    (cmd_vs2),
        .lmul   (cmd_lmul),
        .ok     (legal_ok)
    );

    sm3x_core u_core (
        .old_grp  (vs1_grp),
        .new_grp  (vs2_grp),
        .next_grp (expand_out)
    );

    sm3x_ctrl #(.VL_W(VL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ok     (legal_ok),
        .first_idx  (first_idx),
        .end_idx    (end_idx),
        .cmd_ready  (cmd_ready),
        .rd_en      (rd_en),
        .rd_idx     (rd_idx),
        .grp_result (expand_out),
        .res_valid  (res_valid),
        .res_idx    (res_idx),
        .res_data   (res_data),
        .done       (done),
        .illegal    (illegal)
    );

    // R5: a wrong element width is rejected
    a_r5_width: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_sew != 3'b010) |=> illegal);

    // R6: an unaligned start is rejected
    a_r6_align: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_vstart[2:0] != 3'b000) |=> illegal);

    // R7: identical destination and source groups are rejected
    a_r7_same_group: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_vd == cmd_vs2) |=> illegal);

    // R8: a rejected command produces no read, beat or completion
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!res_valid && !done && !rd_en));

    // R8: the reject flag lasts one cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

endmodule

// File: tb/sim_sm3x_unit.sv
module sim_sm3x_unit;

    localparam int VL_W = 8;
    localparam int GI_W = VL_W - 3;

    typedef struct packed {
        logic [7:0] vl;
        logic [7:0] vs;
        logic [2:0] sew;
        logic [4:0] vd;
        logic [4:0] v2;
        logic [1:0] lm;
        logic       ill;
        logic [7:0] ng;
        logic [3:0] kind;   // requirement tag of the case
    } tcase_t;

    localparam int NCASE = 12;
    localparam tcase_t TABLE [NCASE] = '{
        '{8'd64,  8'd0,   3'b010, 5'd8,  5'd16, 2'd3, 1'b0, 8'd8, 4'd3},
        '{8'd24,  8'd8,   3'b010, 5'd1,  5'd2,  2'd0, 1'b0, 8'd2, 4'd3},
        '{8'd20,  8'd0,   3'b010, 5'd3,  5'd9,  2'd1, 1'b0, 8'd2, 4'd3},
        '{8'd8,   8'd8,   3'b010, 5'd0,  5'd4,  2'd0, 1'b0, 8'd0, 4'd9},
        '{8'd16,  8'd3,   3'b010, 5'd0,  5'd4,  2'd0, 1'b1, 8'd0, 4'd6},
        '{8'd16,  8'd0,   3'b011, 5'd0,  5'd4,  2'd0, 1'b1, 8'd0, 4'd5},
        '{8'd16,  8'd0,   3'b010, 5'd4,  5'd5,  2'd1, 1'b1, 8'd0, 4'd7},
        '{8'd8,   8'd0,   3'b010, 5'd4,  5'd6,  2'd1, 1'b0, 8'd1, 4'd7},
        '{8'd16,  8'd0,   3'b010, 5'd6,  5'd4,  2'd2, 1'b1, 8'd0, 4'd7},
        '{8'd255, 8'd240, 3'b010, 5'd2,  5'd20, 2'd0, 1'b0, 8'd1, 4'd3},
        '{8'd7,   8'd0,   3'b010, 5'd2,  5'd20, 2'd0, 1'b0, 8'd0, 4'd9},
        '{8'd16,  8'd0,   3'b010, 5'd12, 5'd12, 2'd0, 1'b1, 8'd0, 4'd7}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [VL_W-1:0] cmd_vl = '0;
    logic [VL_W-1:0] cmd_vstart = '0;
    logic [2:0]      cmd_sew = 3'b010;
    logic [4:0]      cmd_vd = '0;
    logic [4:0]      cmd_vs2 = 5'd8;
    logic [1:0]      cmd_lmul = '0;
    logic            rd_en;
    logic [GI_W-1:0] rd_idx;
    logic [255:0]    vs1_grp, vs2_grp;
    logic            res_valid;
    logic [GI_W-1:0] res_idx;
    logic [255:0]    res_data;
    logic            done, illegal;

    int seed = 0;
    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    function automatic logic [255:0] gen_grp(input int s, input int gi, input int sel);
        logic [255:0] g;
        logic [31:0]  x;
        g = '0;
        if (s != 0) begin
            for (int k = 0; k < 8; k++) begin
                x = 32'(s) * 32'h01000193 ^ (32'(gi) * 32'h9E3779B9)
                  ^ (32'(k) * 32'h85EBCA6B) ^ (sel != 0 ? 32'hC2B2AE35 : 32'h0);
                x ^= x << 13;
                x ^= x >> 17;
                x ^= x << 5;
                g[32*k +: 32] = x;
            end
        end
        return g;
    endfunction

    function automatic logic [31:0] swp(input logic [31:0] x);
        return {<<8{x}};
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return {x, x} >> (32 - n);
    endfunction

    function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b);
        logic [31:0]  w [24];
        logic [31:0]  t;
        logic [255:0] o;
        for (int k = 0; k < 8; k++) begin
            w[k]   = swp(a[32*k +: 32]);
            w[k+8] = swp(b[32*k +: 32]);
        end
        for (int j = 16; j < 24; j++) begin
            t    = w[j-16] ^ w[j-9] ^ rl(w[j-3], 15);
            w[j] = t ^ rl(t, 15) ^ rl(t, 23) ^ rl(w[j-13], 7) ^ w[j-6];
        end
        for (int k = 0; k < 8; k++) o[32*k +: 32] = swp(w[16+k]);
        return o;
    endfunction

    assign vs1_grp = gen_grp(seed, int'(rd_idx), 0);
    assign vs2_grp = gen_grp(seed, int'(rd_idx), 1);

    sm3x_unit #(.VL_W(VL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vl(cmd_vl), .cmd_vstart(cmd_vstart), .cmd_sew(cmd_sew),
        .cmd_vd(cmd_vd), .cmd_vs2(cmd_vs2), .cmd_lmul(cmd_lmul),
        .rd_en(rd_en), .rd_idx(rd_idx), .vs1_grp(vs1_grp), .vs2_grp(vs2_grp),
        .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
        .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [3:0] k);
        case (k)
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd9: return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic run_case(input tcase_t tc);
        int  nres, first_res, done_at, ill_at, exp_idx;
        bool_t_dummy: begin end
        nres = 0; first_res = -1; done_at = -1; ill_at = -1;
        exp_idx = int'(tc.vs) / 8;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R10 ready when idle", 256'(cmd_ready), 256'(1));
        cmd_vl = tc.vl; cmd_vstart = tc.vs; cmd_sew = tc.sew;
        cmd_vd = tc.vd; cmd_vs2 = tc.v2; cmd_lmul = tc.lm;
        cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            if (rd_en && cmd_ready)
                check(1'b0, "R10 busy while reading", 256'(cmd_ready), 256'(0));
            if (res_valid) begin
                if (first_res < 0) first_res = c;
                check(int'(res_idx) == exp_idx, "R4 beat index",
                      256'(res_idx), 256'(exp_idx));
                check(res_data == model(gen_grp(seed, exp_idx, 0), gen_grp(seed, exp_idx, 1)),
                      "R1 R2 expansion result", res_data,
                      model(gen_grp(seed, exp_idx, 0), gen_grp(seed, exp_idx, 1)));
                exp_idx++;
                nres++;
            end
            if (illegal && ill_at < 0) ill_at = c;
            if (done && done_at < 0) done_at = c;
            if (done || illegal) break;
        end
        check((ill_at >= 0) == tc.ill, tag(tc.kind), 256'(ill_at >= 0), 256'(tc.ill));
        check(nres == int'(tc.ng), "R3 group count", 256'(nres), 256'(tc.ng));
        if (tc.ill) begin
            check(ill_at == 0 && done_at < 0 && nres == 0, "R8 reject quiet",
                  256'(ill_at), 256'(0));
        end else begin
            check(done_at == (tc.ng == 0 ? 0 : int'(tc.ng)), "R9 done timing",
                  256'(done_at), 256'(tc.ng));
            if (tc.ng != 0)
                check(first_res == 1, "R4 first beat latency", 256'(first_res), 256'(1));
        end
    endtask

    initial begin : watchdog
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !rd_en && !res_valid && !done && !illegal, "R11 reset state",
              256'({cmd_ready, rd_en, res_valid, done, illegal}), 256'(5'b10000));
        for (int i = 0; i < NCASE; i++) begin
            seed = i + 1;
            run_case(TABLE[i]);
        end
        // R1: all-zero operands expand to zero
        seed = 0;
        run_case('{8'd16, 8'd0, 3'b010, 5'd0, 5'd8, 2'd0, 1'b0, 8'd2, 4'd3});
        // R1 R2: further random groups across the full index range
        seed = 777;
        run_case('{8'd255, 8'd0, 3'b010, 5'd0, 5'd8, 2'd3, 1'b0, 8'd31, 4'd3});
        // R7: groups touching at the boundary from below are legal
        seed = 99;
        run_case('{8'd8, 8'd0, 3'b010, 5'd8, 5'd0, 2'd3, 1'b0, 8'd1, 4'd7});
        // R11: reset in the middle of a run returns to the idle state
        @(negedge clk);
        cmd_vl = 8'd64; cmd_vstart = 8'd0; cmd_sew = 3'b010;
        cmd_vd = 5'd0; cmd_vs2 = 5'd8; cmd_lmul = 2'd0; cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !rd_en && !res_valid && !done, "R11 reset mid-run",
              256'({cmd_ready, rd_en, res_valid, done}), 256'(4'b1000));
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule